// File: doc/BRIEF.md
# Dynamic-Width External Bus Sequencer

This block sits between a 16-bit processor core and an external bus whose devices answer with an asynchronous handshake. The core hands it one request: a byte, a word or a long word, to read or to write, at any address. The block then runs as many bus cycles as the operand needs. On each cycle it drives the address, a two-bit code for the bytes still to move, the direction and the write lanes. It waits until the responding device reports its port width on an active-low two-bit acknowledge. It then advances by the number of bytes that port took.

The acknowledge arrives from another timing domain, so it passes through a synchronizer before the control decodes it. A new cycle starts only after the acknowledge has been seen released. Requests that fall in a chip-select region marked for fast termination skip the handshake. For these the port width comes with the request, and the cycle ends after a fixed two clocks. When the last byte has moved, a one-clock done pulse is given. For a read, the assembled operand comes with it.

Top module: `dynbus_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the strobe is low, `done` is low and `reqReady` is high.
- R2: `reqSize` 01 requests one byte, 10 a word, 00 (or 11) a long word. During each cycle `busSize` gives the bytes still to move in the current piece: 01 one, 10 two, 11 three, 00 four. It stays stable while the strobe is high.
- R3: A handshake cycle has one address clock, then wait clocks, then one terminate clock. The wait clocks run up to and including the first clock in which the synchronized acknowledge (two flops) is not 11. A device that asserts its acknowledge in the address clock and holds it gives a 4-clock strobe. Each further clock of device delay adds one.
- R4: With `reqFast` set, every cycle of the request keeps the strobe high for exactly 2 clocks. `ackN` has no effect on the cycle, and the port is 16 bits wide when `reqFastWide` is 1, 8 bits otherwise.
- R5: `ackN` = {ack1, ack0}, active low. 01 means a 16-bit port, 10 an 8-bit port, 00 is treated as a 16-bit port, and 11 means keep waiting.
- R6: An 8-bit port takes one byte per cycle. A 16-bit port takes two bytes at an even address when two or more remain, otherwise one. The address advances by the bytes taken.
- R7: A long word at an odd address moves as two word pieces, at A and at A+2. The four-byte code therefore never appears at an odd address, and the three-byte code appears only after the first byte of an even-addressed long word sent to an 8-bit port.
- R8: On writes at an even address the upper lane `busDataOut[15:8]` carries the next operand byte, and the lower lane carries the byte after it (the same byte if only one remains). At an odd address both lanes carry the next byte, so an 8-bit port finds it on the upper lane.
- R9: On reads, a 16-bit port's byte comes from the upper lane at even addresses and the lower lane at odd ones, with both lanes used when two bytes are taken. An 8-bit port uses the upper lane. The other lane is ignored. `rdata` holds the operand right-justified, lowest address in the most significant byte.
- R10: `done` pulses for exactly one clock, in the clock after the last terminate clock, with `rdata` valid. `reqReady` is high only when no transfer is in progress, and never with the strobe or `done`.
- R11: The strobe rises only when the synchronized acknowledge reads 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request accepted this clock |
| reqWrite | input | 1 | 1 write, 0 read |
| reqSize | input | 2 | Operand length code |
| reqAddr | input | ADDR_W | Byte address of first operand byte |
| reqWdata | input | 32 | Write operand, right-justified |
| reqFast | input | 1 | Region uses internal fast termination |
| reqFastWide | input | 1 | Port width for fast termination, 1 = 16 bits |
| done | output | 1 | Transfer complete pulse |
| rdata | output | 32 | Assembled read operand |
| busAddr | output | ADDR_W | Bus address |
| busSize | output | 2 | Remaining-bytes code |
| busStrobe | output | 1 | Cycle active |
| busRnW | output | 1 | 1 read, 0 write |
| busDataOut | output | 16 | Write lanes |
| busDataOe | output | 1 | Write lanes driven |
| busDataIn | input | 16 | Read lanes |
| ackN | input | 2 | Active-low data-size acknowledge {ack1, ack0} |

## Verification
Two things can happen in the same stretch of clocks. The done pulse of one read starts the settling interval, and in the clock after it the bench already presents the next request. At that moment the previous device's acknowledge is still held in the synchronizer. The bench presents requests back to back in this way after every read, so a controller that let the stale acknowledge end the next cycle would give a strobe shorter than the expected four-plus-wait clocks. The scoreboard judges each cycle's address, size code and strobe length, and each read operand, against values derived from the requirements.

// File: rtl/dynbus_pkg.sv
package dynbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_ADDR,
    ST_WAIT,
    ST_TERM
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new request
    logic advance;  // a cycle terminates this clock
    logic port16;   // width of the port that took it
  } ctlStrobe_t;

  localparam logic [1:0] ACK_NONE   = 2'b11;
  localparam logic [1:0] ACK_NARROW = 2'b10;

endpackage

// File: rtl/dynbus_sync.sv
module dynbus_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/dynbus_fsm.sv
module dynbus_fsm
  import dynbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       isFast,
  input  logic       fastWide,
  input  logic       allDone,
  input  logic [1:0] syncAck,
  output logic       reqReady,
  output logic       busStrobe,
  output ctlStrobe_t ctl
);
  busState_e state, stateNext;
  logic      portWide;
  logic      ackSeen;

  assign ackSeen = (syncAck != ACK_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      portWide <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_ADDR && isFast)   portWide <= fastWide;
      if (state == ST_WAIT && ackSeen)  portWide <= (syncAck != ACK_NARROW);
    end
  end

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    ctl.port16  = portWide;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.load  = 1'b1;
        stateNext = ST_SETTLE;
      end
      ST_SETTLE: if (!ackSeen) stateNext = allDone ? ST_IDLE : ST_ADDR;
      ST_ADDR:   stateNext = isFast ? ST_TERM : ST_WAIT;
      ST_WAIT:   if (ackSeen) stateNext = ST_TERM;
      ST_TERM: begin
        ctl.advance = 1'b1;
        stateNext   = ST_SETTLE;
      end
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign reqReady  = (state == ST_IDLE);
  assign busStrobe = (state == ST_ADDR) || (state == ST_WAIT) || (state == ST_TERM);
endmodule

// File: rtl/dynbus_dpath.sv
module dynbus_dpath
  import dynbus_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic              reqFast,
  input  logic              reqFastWide,
  input  logic [15:0]       busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              busRnW,
  output logic [15:0]       busDataOut,
  output logic              isFast,
  output logic              fastWide,
  output logic              allDone,
  output logic              done,
  output logic [31:0]       rdata
);
  localparam int CNT_W = 3;

  logic [ADDR_W-1:0] addrQ;
  logic [31:0]       bufQ;
  logic [CNT_W-1:0]  lenQ, idxQ, chunkQ;
  logic              pendQ, rnwQ, fastQ, fastWideQ, doneQ;

  logic [CNT_W-1:0]  lenIn, acc, remAfter;
  logic              misalIn;
  logic [7:0]        curByte, nextByte;
  logic [31:0]       capBuf;

  function automatic logic [7:0] getByte(input logic [31:0] b, input logic [CNT_W-1:0] n,
                                         input logic [CNT_W-1:0] k);
    logic [1:0] pos;
    pos = 2'(n - 3'd1 - k);
    return 8'(b >> {pos, 3'b000});
  endfunction

  function automatic logic [31:0] setByte(input logic [31:0] b, input logic [CNT_W-1:0] n,
                                          input logic [CNT_W-1:0] k, input logic [7:0] v);
    logic [1:0] pos;
    logic [4:0] sh;
    pos = 2'(n - 3'd1 - k);
    sh  = {pos, 3'b000};
    return (b & ~(32'h0000_00FF << sh)) | (32'(v) << sh);
  endfunction

  always_comb begin
    unique case (reqSize)
      2'b01:   lenIn = 3'd1;
      2'b10:   lenIn = 3'd2;
      default: lenIn = 3'd4;
    endcase
    misalIn = (lenIn == 3'd4) && reqAddr[0];
  end

  assign acc      = (ctl.port16 && !addrQ[0] && chunkQ >= 3'd2) ? 3'd2 : 3'd1;
  assign remAfter = chunkQ - acc;

  always_comb begin
    capBuf = bufQ;
    if (ctl.port16) begin
      if (!addrQ[0]) begin
        capBuf = setByte(capBuf, lenQ, idxQ, busDataIn[15:8]);
        if (acc == 3'd2) capBuf = setByte(capBuf, lenQ, idxQ + 3'd1, busDataIn[7:0]);
      end else begin
        capBuf = setByte(capBuf, lenQ, idxQ, busDataIn[7:0]);
      end
    end else begin
      capBuf = setByte(capBuf, lenQ, idxQ, busDataIn[15:8]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      bufQ      <= '0;
      lenQ      <= '0;
      idxQ      <= '0;
      chunkQ    <= '0;
      pendQ     <= 1'b0;
      rnwQ      <= 1'b1;
      fastQ     <= 1'b0;
      fastWideQ <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (ctl.load) begin
        addrQ     <= reqAddr;
        bufQ      <= reqWrite ? reqWdata : 32'h0;
        lenQ      <= lenIn;
        idxQ      <= '0;
        chunkQ    <= misalIn ? 3'd2 : lenIn;
        pendQ     <= misalIn;
        rnwQ      <= !reqWrite;
        fastQ     <= reqFast;
        fastWideQ <= reqFastWide;
      end else if (ctl.advance) begin
        addrQ <= addrQ + ADDR_W'(acc);
        idxQ  <= idxQ + acc;
        if (remAfter == 3'd0 && pendQ) begin
          chunkQ <= 3'd2;
          pendQ  <= 1'b0;
        end else begin
          chunkQ <= remAfter;
        end
        if (rnwQ) bufQ <= capBuf;
        doneQ <= (remAfter == 3'd0) && !pendQ;
      end
    end
  end

  assign curByte    = getByte(bufQ, lenQ, idxQ);
  assign nextByte   = getByte(bufQ, lenQ, idxQ + 3'd1);
  assign busDataOut = {curByte, (addrQ[0] || chunkQ < 3'd2) ? curByte : nextByte};
  assign busAddr    = addrQ;
  assign busSize    = chunkQ[1:0];
  assign busRnW     = rnwQ;
  assign isFast     = fastQ;
  assign fastWide   = fastWideQ;
  assign allDone    = (chunkQ == 3'd0) && !pendQ;
  assign done       = doneQ;
  assign rdata      = bufQ;
endmodule

// File: rtl/dynbus_ctrl.sv
module dynbus_ctrl
  import dynbus_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic              reqFast,
  input  logic              reqFastWide,
  output logic              done,
  output logic [31:0]       rdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              busStrobe,
  output logic              busRnW,
  output logic [15:0]       busDataOut,
  output logic              busDataOe,
  input  logic [15:0]       busDataIn,
  input  logic [1:0]        ackN
);
  ctlStrobe_t ctl;
  logic [1:0] syncAck;
  logic       isFast, fastWide, allDone;

  dynbus_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rstN(rstN), .din(ackN), .dout(syncAck)
  );

  dynbus_fsm u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isFast(isFast),
    .fastWide(fastWide), .allDone(allDone), .syncAck(syncAck),
    .reqReady(reqReady), .busStrobe(busStrobe), .ctl(ctl)
  );

  dynbus_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqFast(reqFast),
    .reqFastWide(reqFastWide), .busDataIn(busDataIn), .busAddr(busAddr),
    .busSize(busSize), .busRnW(busRnW), .busDataOut(busDataOut),
    .isFast(isFast), .fastWide(fastWide), .allDone(allDone),
    .done(done), .rdata(rdata)
  );

  assign busDataOe = busStrobe & ~busRnW;
endmodule

// File: rtl/dynbus_chk.sv
module dynbus_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busStrobe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic              busRnW,
  input logic [15:0]       busDataOut,
  input logic              done,
  input logic              reqReady,
  input logic [1:0]        syncAck
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe && $past(busStrobe) |-> $stable(busSize) && $stable(busAddr));

  assert_long_even_R7: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe && busSize == 2'b00 |-> !busAddr[0]);

  assert_odd_copy_R8: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe && !busRnW && busAddr[0] |-> busDataOut[15:8] == busDataOut[7:0]);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busStrobe && !done);

  assert_quiet_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busStrobe) |-> syncAck == 2'b11);
endmodule

bind dynbus_ctrl dynbus_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busStrobe(busStrobe), .busAddr(busAddr),
  .busSize(busSize), .busRnW(busRnW), .busDataOut(busDataOut),
  .done(done), .reqReady(reqReady), .syncAck(syncAck)
);

// File: tb/dynbus_ctrl_tb.sv
module dynbus_ctrl_tb;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0, reqFast = 1'b0, reqFastWide = 1'b0;
  logic [1:0]    reqSize = 2'b01;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqWdata = '0;
  logic          reqReady, done, busStrobe, busRnW, busDataOe;
  logic [31:0]   rdata;
  logic [AW-1:0] busAddr;
  logic [1:0]    busSize;
  logic [15:0]   busDataOut;
  logic [15:0]   busDataIn = 16'h0;
  logic [1:0]    ackN = 2'b11;

  always #4 clk = ~clk;  // 125 MHz

  dynbus_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqFast(reqFast), .reqFastWide(reqFastWide), .done(done), .rdata(rdata),
    .busAddr(busAddr), .busSize(busSize), .busStrobe(busStrobe), .busRnW(busRnW),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .busDataIn(busDataIn), .ackN(ackN)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic [1:0]    s;
    int            len;
  } cyc_t;

  cyc_t        cycQ[$];
  logic [32:0] resQ[$];  // bit 32: read
  int          checks = 0, fails = 0, doneCount = 0;

  logic [7:0]  devMem [256];
  logic [7:0]  expMem [256];
  bit          devWide = 1'b1, curFast = 1'b0;
  logic [1:0]  ackCode = 2'b01, fastAckCode = 2'b11;
  int          waitN = 0, devCnt = 0;

  localparam logic [1:0] SZ_B = 2'b01, SZ_W = 2'b10, SZ_L = 2'b00;
  localparam logic [1:0] A16 = 2'b01, A8 = 2'b10, A00 = 2'b00;

  // external device model: answers on the falling edge
  always @(negedge clk) begin
    logic [7:0] da;
    if (!rstN) begin
      devCnt = 0;
      ackN <= 2'b11;
    end else if (busStrobe) begin
      devCnt++;
      if (devCnt == (curFast ? 1 : waitN + 1)) begin
        ackN <= curFast ? fastAckCode : ackCode;
        da = busAddr[7:0];
        if (busRnW) begin
          if (devWide) busDataIn <= da[0] ? {8'hEE, devMem[da]} : {devMem[da], devMem[da + 8'd1]};
          else         busDataIn <= {devMem[da], 8'hEE};
        end else if (devWide) begin
          if (!da[0]) begin
            devMem[da] = busDataOut[15:8];
            if (busSize != 2'b01) devMem[da + 8'd1] = busDataOut[7:0];
          end else begin
            devMem[da] = busDataOut[7:0];
          end
        end else begin
          devMem[da] = busDataOut[15:8];
        end
      end
    end else begin
      devCnt = 0;
      ackN <= 2'b11;
    end
  end

  // bus cycle monitor
  int            runLen = 0;
  logic [AW-1:0] runA;
  logic [1:0]    runS;
  always @(negedge clk) begin
    if (rstN) begin
      if (busStrobe) begin
        if (runLen == 0) begin runA = busAddr; runS = busSize; end
        runLen++;
      end else if (runLen > 0) begin
        checks++;
        if (cycQ.size() == 0) begin
          fails++;
          $display("FAIL R2/R6 unexpected cycle: actual addr %h size %b len %0d, expected none",
                   runA, runS, runLen);
        end else begin
          cyc_t e;
          e = cycQ.pop_front();
          if (e.a !== runA || e.s !== runS || e.len != runLen) begin
            fails++;
            $display("FAIL R2/R3/R4/R5/R6/R7/R11 cycle: actual addr %h size %b len %0d, expected addr %h size %b len %0d",
                     runA, runS, runLen, e.a, e.s, e.len);
          end
        end
        runLen = 0;
      end
    end
  end

  // completion monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      logic [32:0] r;
      doneCount++;
      checks++;
      if (resQ.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected done: actual 1, expected 0");
      end else begin
        r = resQ.pop_front();
        if (r[32] && rdata !== r[31:0]) begin
          fails++;
          $display("FAIL R9 read data: actual %h, expected %h", rdata, r[31:0]);
        end
      end
    end
  end

  task automatic run(input bit wr, input logic [1:0] sz, input logic [7:0] a,
                     input logic [31:0] wd, input bit fst, input bit fw,
                     input logic [1:0] ack, input int w);
    int n, nch, len, tgt;
    int chunk[2];
    bit eff16;
    logic [7:0] ca;
    logic [31:0] ed;
    n     = (sz == SZ_B) ? 1 : (sz == SZ_W) ? 2 : 4;
    eff16 = fst ? fw : (ack != A8);
    len   = fst ? 2 : 4 + w;
    if (n == 4 && a[0]) begin nch = 2; chunk[0] = 2; chunk[1] = 2; end
    else begin nch = 1; chunk[0] = n; chunk[1] = 0; end
    ca = a;
    for (int c = 0; c < nch; c++) begin
      int rem;
      rem = chunk[c];
      while (rem > 0) begin
        int acc;
        cyc_t e;
        acc = (eff16 && !ca[0] && rem >= 2) ? 2 : 1;
        e.a = {16'h0, ca}; e.s = 2'(rem); e.len = len;
        cycQ.push_back(e);
        ca  = ca + 8'(acc);
        rem = rem - acc;
      end
    end
    ed = 0;
    for (int k = 0; k < n; k++) begin
      if (wr) expMem[a + 8'(k)] = 8'(wd >> ((n - 1 - k) * 8));
      else    ed = (ed << 8) | 32'(expMem[a + 8'(k)]);
    end
    resQ.push_back({!wr, ed});
    tgt = doneCount + 1;
    @(negedge clk);
    waitN = w; curFast = fst; devWide = eff16; ackCode = ack;
    reqWrite = wr; reqSize = sz; reqAddr = {16'h0, a}; reqWdata = wd;
    reqFast = fst; reqFastWide = fw; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (doneCount < tgt) @(negedge clk);
    if (wr) begin
      bit ok;
      while (!reqReady) @(negedge clk);
      ok = 1'b1;
      for (int k = 0; k < n; k++) if (devMem[a + 8'(k)] !== expMem[a + 8'(k)]) ok = 1'b0;
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL R8 write at %h: actual %h%h%h%h, expected %h%h%h%h", a,
                 devMem[a], devMem[a+8'd1], devMem[a+8'd2], devMem[a+8'd3],
                 expMem[a], expMem[a+8'd1], expMem[a+8'd2], expMem[a+8'd3]);
      end
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung, expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      devMem[i] = 8'(i * 7 + 3);
      expMem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1: state during reset
    checks++;
    if (busStrobe !== 1'b0 || done !== 1'b0 || reqReady !== 1'b1) begin
      fails++;
      $display("FAIL R1 in reset: actual strobe %b done %b ready %b, expected 0 0 1",
               busStrobe, done, reqReady);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (busStrobe !== 1'b0 || done !== 1'b0 || reqReady !== 1'b1) begin
      fails++;
      $display("FAIL R1 after reset: actual strobe %b done %b ready %b, expected 0 0 1",
               busStrobe, done, reqReady);
    end

    // reads on a 16-bit port (R2 R3 R6 R9), back to back (R11)
    run(0, SZ_B, 8'h10, 0, 0, 0, A16, 0);
    run(0, SZ_B, 8'h11, 0, 0, 0, A16, 1);
    run(0, SZ_W, 8'h20, 0, 0, 0, A16, 2);
    run(0, SZ_W, 8'h21, 0, 0, 0, A16, 0);
    run(0, SZ_L, 8'h30, 0, 0, 0, A16, 0);
    run(0, SZ_L, 8'h33, 0, 0, 0, A16, 1);  // R7 split on wide port
    // 8-bit port: three-byte code (R7), upper lane (R9)
    run(0, SZ_L, 8'h40, 0, 0, 0, A8, 0);
    run(0, SZ_L, 8'h45, 0, 0, 0, A8, 3);
    // R5: both acknowledge lines low acts as 16-bit
    run(0, SZ_W, 8'h50, 0, 0, 0, A00, 1);
    run(0, SZ_L, 8'h54, 0, 0, 0, A00, 0);
    // writes (R8)
    run(1, SZ_W, 8'h61, 32'h0000_A1B2, 0, 0, A8, 0);
    run(1, SZ_L, 8'h70, 32'hC0C1_C2C3, 0, 0, A16, 2);
    run(1, SZ_B, 8'h81, 32'h0000_005A, 0, 0, A16, 0);
    run(1, SZ_L, 8'h91, 32'hD4D5_D6D7, 0, 0, A8, 1);
    run(1, SZ_L, 8'hA3, 32'h0102_0304, 0, 0, A16, 0);
    run(0, SZ_L, 8'hA3, 0, 0, 0, A16, 0);
    run(0, SZ_W, 8'h61, 0, 0, 0, A16, 6);
    // fast termination (R4): device acknowledge contradicts the width
    fastAckCode = A8;
    run(0, SZ_L, 8'h70, 0, 1, 1, A16, 0);
    run(1, SZ_W, 8'hB1, 32'h0000_BEEF, 1, 0, A16, 0);
    fastAckCode = 2'b11;
    run(0, SZ_W, 8'hB1, 0, 1, 1, A16, 0);
    run(0, SZ_L, 8'h91, 0, 1, 0, A16, 0);
    run(0, SZ_B, 8'h81, 0, 0, 0, A8, 2);

    while (!reqReady) @(negedge clk);
    repeat (4) @(negedge clk);
    checks++;
    if (cycQ.size() != 0 || resQ.size() != 0) begin
      fails++;
      $display("FAIL R10 pending items: actual %0d cycles %0d results, expected 0 0",
               cycQ.size(), resQ.size());
    end
    finishRun();
  end
endmodule